// File: doc/BRIEF.md
# Wait-Edge and Access-Timeout Interrupt Collector

This block gathers two kinds of events into one level-sensitive interrupt line. One kind is a single-cycle timeout pulse from the external-memory strobe sequencer. That sequencer raises the pulse when a strobe extension reaches its maximum cycle count and the wait pin is still active. The other kind is a rising edge on any of the wait pins coming from attached devices. A device such as a NAND flash uses this edge to report that it is ready.

Each event sets a sticky bit in a raw status word. Bit 0 is the timeout bit and bit 1+i is the rising-edge bit of wait pin i. Software clears a raw bit by writing one to it. An enable mask gates which raw bits can reach the interrupt line. The mask is only changed through two write addresses: one sets bits and the other clears them. The wait pins are asynchronous, so each one passes through a synchronizer before its edge detector. Edge detection always looks at the physical pin level and never at a configured polarity.

Register map, 2-bit address: 0 is raw status (read; write-one-to-clear), 1 is masked status (read-only), 2 is mask set (write; reads back the mask), 3 is mask clear (write; reads back the mask).

Top module: `wirq_ctrl`

## Requirements
- R1: After reset, the raw status, mask, masked status and `irq_o` are all zero.
- R2: A high `tmo_pulse_i` at a clock edge sets raw bit 0 at that edge.
- R3: When a wait pin goes from 0 to 1 before clock edge k, raw bit 1+i becomes visible after edge k+2 and not before. A falling edge or a steady level sets nothing.
- R4: Raw bits stay set until software writes a 1 to that bit position at address 0. Writing 0 leaves the bit unchanged.
- R5: When a set event and a write-one-to-clear hit the same raw bit in the same cycle, the bit ends up set.
- R6: A write to address 2 sets the mask bits where the data holds 1. A write to address 3 clears them. Zero data bits leave the mask unchanged. Reads of address 2 or 3 return the mask.
- R7: Address 1 reads raw AND mask. Writes to address 1 change neither the raw status nor the mask.
- R8: `irq_o` is a register. After each edge it equals the OR of the masked status that held before that edge, so it lags the masked status by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_pulse_i | input | 1 | Access-timeout pulse from the strobe sequencer |
| wait_pin_i | input | NUM_WAIT | Asynchronous wait pins, raw level |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | NUM_WAIT+1 | Write data |
| reg_rdata_o | output | NUM_WAIT+1 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The bench checks the edge latency exactly. It samples just before and just after the cycle in which the raw bit should appear, so a synchronizer that is one stage too short or too long is caught. It runs a timeout pulse in the same cycle as a clear of that bit: a design that lets the clear win would lose the event. It writes zeros to the clear addresses and writes to the read-only masked address; a design that decodes data or address loosely would corrupt the state. It also checks that `irq_o` lags by exactly one cycle and that a falling wait pin never sets a bit.

// File: rtl/wirq_pkg.sv
package wirq_pkg;

    typedef enum logic [1:0] {
        REG_RAW    = 2'd0,
        REG_MASKED = 2'd1,
        REG_MSET   = 2'd2,
        REG_MCLR   = 2'd3
    } wirq_reg_e;

    typedef struct packed {
        logic      we;
        wirq_reg_e addr;
    } wirq_cmd_t;

    localparam int TMO_BIT = 0;

    function automatic int wait_bit(input int pin);
        return pin + 1;
    endfunction

endpackage

// File: rtl/wirq_sync_edge.sv
module wirq_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;

    // R3: an edge comes only from a 0 -> 1 step at the synchronizer output
    assert_edge_source_R3: assert property (@(posedge clk) disable iff (rst)
        rise_o |-> ($past(chain_q[STAGES-2]) && !prev_q));

endmodule

// File: rtl/wirq_status.sv
module wirq_status #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_ev_i,
    input  logic [NSRC-1:0] w1c_i,
    output logic [NSRC-1:0] raw_o
);
    logic [NSRC-1:0] raw_q;

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= (raw_q & ~w1c_i) | set_ev_i;
    end

    assign raw_o = raw_q;

    // R2, R5: every set event lands, even against a same-cycle clear
    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((raw_q & $past(set_ev_i)) == $past(set_ev_i)));

    // R4: a bit only drops when it was written with one
    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(raw_q) & ~raw_q) & ~$past(w1c_i)) == '0));

endmodule

// File: rtl/wirq_mask.sv
module wirq_mask #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] mask_o
);
    logic [NSRC-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= (mask_q | set_i) & ~clr_i;
    end

    assign mask_o = mask_q;

    // R6: set bits appear, untouched bits hold
    assert_mask_set_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(clr_i) == '0) |-> ((mask_q & $past(set_i)) == $past(set_i)));

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((mask_q ^ $past(mask_q)) & ~($past(set_i) | $past(clr_i))) == '0));

endmodule

// File: rtl/wirq_ctrl.sv
module wirq_ctrl
    import wirq_pkg::*;
#(
    parameter int NUM_WAIT    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tmo_pulse_i,
    input  logic [NUM_WAIT-1:0] wait_pin_i,
    input  logic                reg_we_i,
    input  logic [1:0]          reg_addr_i,
    input  logic [NUM_WAIT:0]   reg_wdata_i,
    output logic [NUM_WAIT:0]   reg_rdata_o,
    output logic                irq_o
);
    localparam int NSRC = NUM_WAIT + 1;

    wirq_cmd_t       cmd;
    logic [NSRC-1:0] set_ev;
    logic [NSRC-1:0] w1c;
    logic [NSRC-1:0] mset;
    logic [NSRC-1:0] mclr;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] mask;
    logic [NSRC-1:0] masked;
    logic            irq_q;

    assign cmd.we   = reg_we_i;
    assign cmd.addr = wirq_reg_e'(reg_addr_i);

    assign set_ev[TMO_BIT] = tmo_pulse_i;

    for (genvar i = 0; i < NUM_WAIT; i++) begin : g_wait
        wirq_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (wait_pin_i[i]),
            .rise_o (set_ev[wait_bit(i)])
        );
    end

    always_comb begin
        w1c  = '0;
        mset = '0;
        mclr = '0;
        if (cmd.we) begin
            unique case (cmd.addr)
                REG_RAW:    w1c  = reg_wdata_i;
                REG_MSET:   mset = reg_wdata_i;
                REG_MCLR:   mclr = reg_wdata_i;
                default:    ;
            endcase
        end
    end

    wirq_status #(.NSRC(NSRC)) u_status (
        .clk      (clk),
        .rst      (rst),
        .set_ev_i (set_ev),
        .w1c_i    (w1c),
        .raw_o    (raw)
    );

    wirq_mask #(.NSRC(NSRC)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .set_i  (mset),
        .clr_i  (mclr),
        .mask_o (mask)
    );

    assign masked = raw & mask;

    always_comb begin
        unique case (cmd.addr)
            REG_RAW:    reg_rdata_o = raw;
            REG_MASKED: reg_rdata_o = masked;
            default:    reg_rdata_o = mask;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |masked;
    end

    assign irq_o = irq_q;

    // R8: the line follows the previous cycle's masked status
    assert_irq_follow_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == |$past(raw & mask)));

    // R7: a write to the masked address disturbs no state
    assert_masked_ro_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_we_i && reg_addr_i == 2'd1) |=> ($stable(mask) && ((($past(raw) & ~raw)) == '0)));

    // R1: reset clears everything
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (raw == '0 && mask == '0 && irq_o == 1'b0));

endmodule

// File: tb/wirq_ctrl_bench.sv
module wirq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 2;
    localparam int NV = 12;

    // fields: req, tmo, we, addr, wdata, rd_addr, exp_rdata, exp_irq
    typedef struct packed {
        logic [3:0] req;
        logic       tmo;
        logic       we;
        logic [1:0] addr;
        logic [2:0] wdata;
        logic [1:0] rd_addr;
        logic [2:0] exp_rd;
        logic       exp_irq;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b1, 1'b0, 2'd0, 3'b000, 2'd0, 3'b001, 1'b0}, // R2 timeout sets bit0
        '{4'd6, 1'b0, 1'b1, 2'd2, 3'b001, 2'd1, 3'b001, 1'b1}, // R6 mask set, R7 masked read
        '{4'd6, 1'b0, 1'b1, 2'd2, 3'b110, 2'd2, 3'b111, 1'b1}, // R6 set accumulates
        '{4'd6, 1'b0, 1'b1, 2'd3, 3'b001, 2'd2, 3'b110, 1'b0}, // R6 clear, R8 drops
        '{4'd4, 1'b0, 1'b1, 2'd0, 3'b000, 2'd0, 3'b001, 1'b0}, // R4 zero write keeps
        '{4'd7, 1'b0, 1'b1, 2'd1, 3'b111, 2'd1, 3'b000, 1'b0}, // R7 write ignored
        '{4'd7, 1'b0, 1'b0, 2'd0, 3'b000, 2'd0, 3'b001, 1'b0}, // R7 raw intact
        '{4'd8, 1'b0, 1'b1, 2'd2, 3'b001, 2'd1, 3'b001, 1'b1}, // R8 irq raised
        '{4'd5, 1'b1, 1'b1, 2'd0, 3'b001, 2'd0, 3'b001, 1'b1}, // R5 set wins
        '{4'd4, 1'b0, 1'b1, 2'd0, 3'b001, 2'd0, 3'b000, 1'b0}, // R4 w1c clears
        '{4'd6, 1'b0, 1'b1, 2'd3, 3'b000, 2'd2, 3'b111, 1'b0}, // R6 zero clear keeps
        '{4'd6, 1'b0, 1'b1, 2'd3, 3'b111, 2'd3, 3'b000, 1'b0}  // R6 full clear
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tmo = 1'b0;
    logic [NW-1:0] pins = '0;
    logic          we = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [NW:0]   wdata = '0;
    logic [NW:0]   rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wirq_ctrl #(.NUM_WAIT(NW), .SYNC_STAGES(2)) u_wirq_ctrl (
        .clk         (clk),
        .rst         (rst),
        .tmo_pulse_i (tmo),
        .wait_pin_i  (pins),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic check(input string tag, input logic [NW:0] act, input logic [NW:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [NW:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd_check(input string tag, input logic [1:0] a, input logic [NW:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_check("R1 raw", 2'd0, 3'b000);
        rd_check("R1 masked", 2'd1, 3'b000);
        rd_check("R1 mask", 2'd2, 3'b000);
        check("R1 irq", {2'b00, irq}, 3'b000);

        foreach (VECS[v]) begin
            @(negedge clk);
            tmo = VECS[v].tmo; we = VECS[v].we;
            addr = VECS[v].addr; wdata = VECS[v].wdata;
            @(negedge clk);
            tmo = 1'b0; we = 1'b0; wdata = '0; addr = VECS[v].rd_addr;
            @(negedge clk);
            n_chk++;
            if (rdata !== VECS[v].exp_rd) begin
                n_bad++;
                $display("FAIL R%0d vector %0d rdata actual=%b expected=%b",
                         VECS[v].req, v, rdata, VECS[v].exp_rd);
            end
            n_chk++;
            if (irq !== VECS[v].exp_irq) begin
                n_bad++;
                $display("FAIL R%0d vector %0d irq actual=%b expected=%b",
                         VECS[v].req, v, irq, VECS[v].exp_irq);
            end
        end

        // R3 exact latency on pin 0; mask is zero here
        @(negedge clk);
        addr = 2'd0;
        pins[0] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R3 early", rdata, 3'b000);
        @(posedge clk); #1;
        check("R3 on time", rdata, 3'b010);
        wr(2'd0, 3'b010);
        rd_check("R3 cleared", 2'd0, 3'b000);

        // R3 falling edge and steady level set nothing
        @(negedge clk);
        pins[0] = 1'b0;
        repeat (6) @(negedge clk);
        rd_check("R3 fall", 2'd0, 3'b000);

        // R8 latency on pin 1 with its mask enabled
        wr(2'd2, 3'b100);
        @(negedge clk);
        pins[1] = 1'b1;
        @(posedge clk); @(posedge clk); @(posedge clk); #1;
        check("R8 irq lag", {2'b00, irq}, 3'b000);
        rd_check("R3 pin1", 2'd1, 3'b100);
        @(posedge clk); #1;
        check("R8 irq set", {2'b00, irq}, 3'b001);

        // R3 both pins independent: pin0 rises, pin1 held high
        @(negedge clk);
        pins[0] = 1'b1;
        repeat (4) @(negedge clk);
        rd_check("R3 both", 2'd0, 3'b110);
        wr(2'd0, 3'b110);
        repeat (2) @(negedge clk);
        rd_check("R4 clear both", 2'd0, 3'b000);
        @(posedge clk); #1;
        check("R8 irq clear", {2'b00, irq}, 3'b000);

        // R1 reset again clears mask and status
        @(negedge clk);
        tmo = 1'b1;
        @(negedge clk);
        tmo = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; pins = '0;
        rd_check("R1 re-reset raw", 2'd0, 3'b000);
        rd_check("R1 re-reset mask", 2'd3, 3'b000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule